// File: doc/BRIEF.md
# SHA-1 Compression Round Engine

This block applies the SHA-1 compression function to one 512-bit message block. Each run starts from a 160-bit chaining value and returns the updated 160-bit state. A one-cycle start request loads the block and the chaining value. The engine then performs one round per clock for 80 rounds. One further cycle adds the working words back onto the chaining value, and a one-cycle done pulse marks the result. Padding the message and chaining several blocks together are left to the surrounding logic.

The round datapath is arranged so that no clock period contains more than one full-width carry-propagate addition. The round update needs the sum of five 32-bit words. The term E + K + W of the next round is formed one round early and kept in a register. This works because the next E is the current D, so it is already known. In the round itself, rotl5(A), the boolean function output and the stored term pass through a 3:2 carry-save stage, followed by a single 32-bit add. The early term is built the same way: one carry-save stage, then one add.

Top module: `sha1_round_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0 and digest_o is all zeros.
- R2: The 160-bit result equals the SHA-1 compression of block_i and chain_i. Word H0 is chain_i[159:128] and H4 is chain_i[31:0]. Message word W0 is block_i[511:480] and W15 is block_i[31:0]. The digest uses the same word order as chain_i.
- R3: done_o is high for exactly one cycle. It rises 81 rising edges after the edge that accepted the start request.
- R4: A start request is accepted only when busy_o is 0. busy_o is 1 from the edge after acceptance until the cycle in which done_o rises, and done_o and busy_o are never high together.
- R5: A start request while busy_o is 1 has no effect: the running result and its completion time are unchanged.
- R6: digest_o holds its value at all times except when a new result is written in a done cycle.
- R7: A start request in the cycle where done_o is high is accepted, so blocks can run back to back.
- R8: Round t uses Ch with 0x5A827999 for t below 20, Parity with 0x6ED9EBA1 for 20 to 39, Maj with 0x8F1BBCDC for 40 to 59, and Parity with 0xCA62C1D6 for 60 to 79.
- R9: In every round, the stored early term equals the current E plus that round's constant plus that round's message word, modulo 2^32.
- R10: Each 3:2 carry-save stage produces a sum and a carry word whose total equals the total of its three inputs modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to load a block and a chaining value |
| block_i | input | 512 | Message block, W0 in the top word |
| chain_i | input | 160 | Input chaining value, H0 in the top word |
| busy_o | output | 1 | Engine is processing a block |
| done_o | output | 1 | One-cycle pulse: digest_o holds a new result |
| digest_o | output | 160 | Updated chaining value |

## Verification
The assertions rely on block_i and chain_i being known, valid values at the edge that accepts a start. Data presented at any other time is never looked at. They also rely on start_i being a clean, synchronous level that may be held or repeated at any time, including mid-run. The bench changes all inputs on the falling edge only. It fires extra start requests during a run, including ones that carry different data, so the ignore path is exercised without breaking these assumptions.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
    localparam int WORD_W      = 32;
    localparam int MSG_WORDS   = 16;
    localparam int STATE_WORDS = 5;
    localparam int ROUNDS      = 80;
    localparam int BLOCK_W     = WORD_W * MSG_WORDS;
    localparam int CHAIN_W     = WORD_W * STATE_WORDS;
    localparam int RND_W       = $clog2(ROUNDS + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
    } work_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_FOLD
    } eng_state_e;

    function automatic word_t rotl(input word_t x, input int n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t round_k(input logic [RND_W-1:0] t);
        if (t < 20)      return 32'h5A827999;
        else if (t < 40) return 32'h6ED9EBA1;
        else if (t < 60) return 32'h8F1BBCDC;
        else             return 32'hCA62C1D6;
    endfunction

    function automatic word_t round_f(input logic [RND_W-1:0] t,
                                      input word_t b, input word_t c, input word_t d);
        if (t < 20)      return (b & c) | (~b & d);
        else if (t < 40) return b ^ c ^ d;
        else if (t < 60) return (b & c) | (b & d) | (c & d);
        else             return b ^ c ^ d;
    endfunction
endpackage

// File: rtl/sha1_csa.sv
module sha1_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    assign carry_o[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
        if (i > 0) begin : g_carry
            assign carry_o[i] = (x_i[i-1] & y_i[i-1]) | (x_i[i-1] & z_i[i-1])
                              | (y_i[i-1] & z_i[i-1]);
        end
    end

    // R10: the two outputs carry the same total as the three inputs
    always_comb begin
        a_r10_csa_total: assert (W'(sum_o + carry_o) == W'(x_i + y_i + z_i));
    end
endmodule

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               shift_i,
    input  logic [BLOCK_W-1:0] block_i,
    output word_t              w_cur_o,
    output word_t              w_next_o
);
    word_t win_d [MSG_WORDS];
    word_t win_q [MSG_WORDS];

    always_comb begin
        for (int i = 0; i < MSG_WORDS; i++) win_d[i] = win_q[i];
        if (load_i) begin
            for (int i = 0; i < MSG_WORDS; i++)
                win_d[i] = block_i[BLOCK_W-1-WORD_W*i -: WORD_W];
        end else if (shift_i) begin
            for (int i = 0; i < MSG_WORDS-1; i++) win_d[i] = win_q[i+1];
            win_d[MSG_WORDS-1] = rotl(win_q[13] ^ win_q[8] ^ win_q[2] ^ win_q[0], 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MSG_WORDS; i++) win_q[i] <= '0;
        end else begin
            for (int i = 0; i < MSG_WORDS; i++) win_q[i] <= win_d[i];
        end
    end

    assign w_cur_o  = win_q[0];
    assign w_next_o = win_q[1];
endmodule

// File: rtl/sha1_round_engine.sv
module sha1_round_engine
    import sha1_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic [CHAIN_W-1:0] chain_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [CHAIN_W-1:0] digest_o
);
    typedef struct packed {
        eng_state_e         st;
        logic [RND_W-1:0]   rnd;
        work_t              work;
        work_t              hin;
        word_t              pre;
        logic               done;
        logic [CHAIN_W-1:0] digest;
    } eng_regs_t;

    eng_regs_t r_d, r_q;

    logic  accept, running;
    word_t w_cur, w_next;
    work_t chain_w;

    assign chain_w = work_t'(chain_i);
    assign accept  = (r_q.st == ENG_IDLE) && start_i;
    assign running = (r_q.st == ENG_RUN);

    sha1_msg_window u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .shift_i  (running),
        .block_i  (block_i),
        .w_cur_o  (w_cur),
        .w_next_o (w_next)
    );

    // Round path: rotl5(A) + f + early term, one carry-save stage then one add
    word_t rnd_s, rnd_c, new_a;
    sha1_csa #(.W(WORD_W)) u_round_csa (
        .x_i     (rotl(r_q.work.a, 5)),
        .y_i     (round_f(r_q.rnd, r_q.work.b, r_q.work.c, r_q.work.d)),
        .z_i     (r_q.pre),
        .sum_o   (rnd_s),
        .carry_o (rnd_c)
    );
    assign new_a = rnd_s + rnd_c;

    // Early-term path: next E (load: H4, run: D) + K + W, same depth
    word_t pe_x, pe_y, pe_z, pe_s, pe_c, pre_sum;
    always_comb begin
        if (accept) begin
            pe_x = chain_w.e;
            pe_y = round_k('0);
            pe_z = block_i[BLOCK_W-1 -: WORD_W];
        end else begin
            pe_x = r_q.work.d;
            pe_y = round_k(r_q.rnd + 1'b1);
            pe_z = w_next;
        end
    end
    sha1_csa #(.W(WORD_W)) u_pre_csa (
        .x_i     (pe_x),
        .y_i     (pe_y),
        .z_i     (pe_z),
        .sum_o   (pe_s),
        .carry_o (pe_c)
    );
    assign pre_sum = pe_s + pe_c;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ENG_IDLE: begin
                if (start_i) begin
                    r_d.st   = ENG_RUN;
                    r_d.rnd  = '0;
                    r_d.work = chain_w;
                    r_d.hin  = chain_w;
                    r_d.pre  = pre_sum;
                end
            end
            ENG_RUN: begin
                r_d.work.a = new_a;
                r_d.work.b = r_q.work.a;
                r_d.work.c = rotl(r_q.work.b, 30);
                r_d.work.d = r_q.work.c;
                r_d.work.e = r_q.work.d;
                r_d.pre    = pre_sum;
                r_d.rnd    = r_q.rnd + 1'b1;
                if (r_q.rnd == RND_W'(ROUNDS - 1)) r_d.st = ENG_FOLD;
            end
            ENG_FOLD: begin
                r_d.digest = {r_q.hin.a + r_q.work.a, r_q.hin.b + r_q.work.b,
                              r_q.hin.c + r_q.work.c, r_q.hin.d + r_q.work.d,
                              r_q.hin.e + r_q.work.e};
                r_d.done   = 1'b1;
                r_d.st     = ENG_IDLE;
            end
            default: r_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o   = (r_q.st != ENG_IDLE);
    assign done_o   = r_q.done;
    assign digest_o = r_q.digest;

    // R3: the completion pulse lasts one cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R4: completion and busy never overlap
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R4: an idle start is taken on the next edge
    a_r4_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);
    // R5: a start during a run does not restart or abort it
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i) |=> (busy_o && r_q.rnd == RND_W'($past(r_q.rnd) + 1)));
    // R6: the result only moves in a completion cycle
    a_r6_digest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(digest_o));
    // R9: the stored early term matches this round's E, K and W
    a_r9_early_term: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (r_q.pre == word_t'(r_q.work.e + round_k(r_q.rnd) + w_cur)));
endmodule

// File: tb/sha1_round_engine_test.sv
module sha1_round_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int LATENCY    = 81;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [159:0] chain_i = '0;
    logic         busy_o, done_o;
    logic [159:0] digest_o;

    int checks = 0;
    int errors = 0;

    localparam logic [159:0] H_INIT = {32'h67452301, 32'hEFCDAB89, 32'h98BADCFE,
                                       32'h10325476, 32'hC3D2E1F0};

    sha1_round_engine uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
        .chain_i(chain_i), .busy_o(busy_o), .done_o(done_o), .digest_o(digest_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [159:0] ref_compress(input logic [159:0] h, input logic [511:0] blk);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, t;
        for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        a = h[159:128]; b = h[127:96]; c = h[95:64]; d = h[63:32]; e = h[31:0];
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
            else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
            t = rl(a, 5) + f + e + k + w[i];
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[32*i +: 32] = $urandom;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [159:0] act,
                         input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [159:0] h, input logic [511:0] b);
        @(negedge clk);
        start_i = 1'b1; chain_i = h; block_i = b;
        @(negedge clk);
        start_i = 1'b0; block_i = '0; chain_i = '0;
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic run_one(input logic [159:0] h, input logic [511:0] b, input string tag);
        int lat;
        issue(h, b);
        check(busy_o == 1'b1, "R4 busy after accept", 160'(busy_o), 160'd1);
        wait_done(lat);
        check(lat == LATENCY, "R3 latency", 160'(lat), 160'(LATENCY));
        check(digest_o == ref_compress(h, b), {"R2 digest ", tag}, digest_o, ref_compress(h, b));
        check(busy_o == 1'b0, "R4 busy low at done", 160'(busy_o), 160'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [511:0] abc_blk, blk_a, blk_b;
        logic [159:0] h_r, held;
        int lat;
        void'($urandom(32'd2718));
        abc_blk = {32'h61626380, {14{32'h0}}, 32'h00000018};

        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy_o == 1'b0, "R1 busy", 160'(busy_o), 160'd0);
        check(done_o == 1'b0, "R1 done", 160'(done_o), 160'd0);
        check(digest_o == '0, "R1 digest", digest_o, 160'd0);
        rst_n = 1'b1;

        // R2/R8: known vector, all four round ranges in play
        run_one(H_INIT, abc_blk, "abc ref");
        check(digest_o == 160'hA9993E364706816ABA3E25717850C26C9CD0D89D, "R8 abc constant",
              digest_o, 160'hA9993E364706816ABA3E25717850C26C9CD0D89D);

        // R6/R3: result held, pulse gone
        held = digest_o;
        repeat (5) @(negedge clk);
        check(digest_o == held, "R6 digest hold", digest_o, held);
        check(done_o == 1'b0, "R3 single pulse", 160'(done_o), 160'd0);

        // R2: random blocks and chaining values, plus all-ones and all-zero corners
        for (int n = 0; n < 6; n++) begin
            h_r = {$urandom, $urandom, $urandom, $urandom, $urandom};
            run_one(h_r, rand_block(), "random");
        end
        run_one({160{1'b1}}, {512{1'b1}}, "all ones");
        run_one('0, '0, "all zero");

        // R5: start with other data mid-run is ignored
        blk_a = rand_block(); blk_b = rand_block();
        issue(H_INIT, blk_a);
        lat = 0;
        while (!done_o && lat < 200) begin
            if (lat == 10 || lat == 79) begin
                start_i = 1'b1; block_i = blk_b; chain_i = '1;
            end else begin
                start_i = 1'b0; block_i = '0; chain_i = '0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 1'b0;
        check(lat == LATENCY, "R5 latency unchanged", 160'(lat), 160'(LATENCY));
        check(digest_o == ref_compress(H_INIT, blk_a), "R5 digest unchanged",
              digest_o, ref_compress(H_INIT, blk_a));
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R5 no late restart", 160'(busy_o), 160'd0);

        // R7: back-to-back start in the done cycle
        issue(H_INIT, blk_a);
        wait_done(lat);
        check(digest_o == ref_compress(H_INIT, blk_a), "R7 first digest",
              digest_o, ref_compress(H_INIT, blk_a));
        start_i = 1'b1; block_i = blk_b; chain_i = H_INIT;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R7 accepted in done cycle", 160'(busy_o), 160'd1);
        wait_done(lat);
        check(lat == LATENCY, "R7 latency", 160'(lat), 160'(LATENCY));
        check(digest_o == ref_compress(H_INIT, blk_b), "R7 second digest",
              digest_o, ref_compress(H_INIT, blk_b));

        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule